// File: doc/BRIEF.md
# Power-On Strap Capture and Shared-Pin Turnaround Controller

This block manages a small group of pads that carry configuration straps while the chip powers up and then become clock outputs. A single control pin has two roles. Before configuration is taken it is a level-sensitive, active-high "power is good" strobe; its first high level, seen through a synchronizer, causes the strap levels to be stored in a latch. From then on the same pin is an active-low, asynchronous power-down request.

Once the straps are stored, the pads are turned around from input to output one clock later, so a pad is never driven while it is being sampled. A stabilization timer holds the clocks-valid flag low for a programmable number of cycles after capture and again after every release of power-down. Asserting power-down drops the clocks-valid flag at once, without waiting for a clock. The stored strap word is the power-up default of the frequency-select field used elsewhere; it is taken once per power cycle and is not sampled again until the next power-on reset.

All pins are plain control and status signals. The strap word has no handshake: it is constant from capture until the next power-on reset.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While `por_n_i` is low, `strap_word_o` is all zeros, `pad_oe_o` is all zeros, `pwr_down_o` is 0 and `clk_valid_o` is 0, without waiting for a clock edge.
- R2: When `pgood_pd_i` goes high, `strap_word_o` bit i takes the level of `strap_pins_i` bit i, and it changes at the third rising clock edge after the rise of `pgood_pd_i` (two synchronizer stages, then the latch).
- R3: After capture, the strap word never changes again in the same power cycle, whatever `strap_pins_i` and `pgood_pd_i` do.
- R4: Every bit of `pad_oe_o` is 0 until one clock after capture, then becomes 1 and stays 1, including while power-down is asserted.
- R5: Before capture, a low level on `pgood_pd_i` is not a power-down: `pwr_down_o` stays 0.
- R6: After capture, a low level on `pgood_pd_i` drives `pwr_down_o` to 1 and `clk_valid_o` to 0 immediately, with no clock edge in between.
- R7: After capture, `clk_valid_o` rises at the rising edge STAB_CYCLES + 3 after the rise of `pgood_pd_i`, and is 0 one edge earlier.
- R8: After power-down is released (pin back high after staying low at least three clocks), `pwr_down_o` returns to 0 at once and `clk_valid_o` rises at the rising edge STAB_CYCLES + 2 after the release, and is 0 one edge earlier.
- R9: A new power-on reset rearms the latch, so the following power-good rise captures the strap levels present then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| strap_pins_i | input | NUM_STRAPS | Raw strap levels read from the shared pads |
| pgood_pd_i | input | 1 | Power-good strobe before capture, active-low power-down after |
| strap_word_o | output | NUM_STRAPS | Captured strap word, bit i from pad i |
| pad_oe_o | output | NUM_STRAPS | Per-pad output enable, 1 turns the pad into a clock output |
| pwr_down_o | output | 1 | Power-down request, asynchronous |
| clk_valid_o | output | 1 | Clocks are stable and may be used |

## Verification
The hardest situation to reach is the role change of the shared control pin: the same low level must be ignored before capture and act with no clock edge after it. The stimulus first holds the pin low after reset to show no power-down, then raises it to capture, then lowers it halfway between clock edges and samples the outputs a nanosecond later, before any edge can act. While the pin is low the strap pins are flipped, and the bench later reads back the strap word to show it was not sampled again; a second power-on reset then shows that the latch is rearmed.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Phase of the shared control pin: strobe before capture, power-down after.
  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_RUN    = 1'b1
  } strap_phase_e;

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q[0] <= '0;
    else          stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) stage_q[s] <= '0;
      else          stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             pgood_sync_i,
  input  logic [WIDTH-1:0] straps_sync_i,
  output logic [WIDTH-1:0] word_o,
  output logic             captured_o
);

  strap_phase_e     phase_q;
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_SAMPLE;
      word_q  <= '0;
    end else if (phase_q == PH_SAMPLE && pgood_sync_i) begin
      phase_q <= PH_RUN;
      word_q  <= straps_sync_i;
    end
  end

  assign word_o     = word_q;
  assign captured_o = (phase_q == PH_RUN);

  // R3: one capture per power cycle, the phase never goes back
  assert_phase_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(phase_q == PH_RUN) |-> (phase_q == PH_RUN));

  // R3: the word is frozen while in the run phase
  assert_word_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_q == PH_RUN && $past(phase_q == PH_RUN)) |-> $stable(word_q));

endmodule

// File: rtl/stab_timer.sv
module stab_timer
  import strap_pkg::*;
#(
  parameter int CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic arm_i,
  input  logic pin_ok_i,
  output logic done_o
);

  localparam int CW = cnt_bits(CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                cnt_q <= '0;
    else if (!arm_i || !pin_ok_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)      cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == LIMIT);

  // R7: the counter saturates at its limit
  assert_count_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LIMIT);

  // R8: a power-down seen by the synchronizer restarts the wait
  assert_restart_on_pd_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(pin_ok_i) |=> !done_o);

endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
  import strap_pkg::*;
#(
  parameter int NUM_STRAPS  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 32
) (
  input  logic                  clk_i,
  input  logic                  por_n_i,
  input  logic [NUM_STRAPS-1:0] strap_pins_i,
  input  logic                  pgood_pd_i,
  output logic [NUM_STRAPS-1:0] strap_word_o,
  output logic [NUM_STRAPS-1:0] pad_oe_o,
  output logic                  pwr_down_o,
  output logic                  clk_valid_o
);

  localparam int SW = NUM_STRAPS + 1;

  logic [SW-1:0]         sync_q;
  logic [NUM_STRAPS-1:0] straps_sync;
  logic                  pin_sync;
  logic                  captured;
  logic                  stab_done;
  logic                  oe_q;

  // Straps and control pin share one synchronizer so they stay aligned.
  strap_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_n_i(por_n_i),
    .d_i    ({pgood_pd_i, strap_pins_i}),
    .q_o    (sync_q)
  );

  assign straps_sync = sync_q[NUM_STRAPS-1:0];
  assign pin_sync    = sync_q[NUM_STRAPS];

  strap_latch #(.WIDTH(NUM_STRAPS)) u_latch (
    .clk_i        (clk_i),
    .rst_n_i      (por_n_i),
    .pgood_sync_i (pin_sync),
    .straps_sync_i(straps_sync),
    .word_o       (strap_word_o),
    .captured_o   (captured)
  );

  stab_timer #(.CYCLES(STAB_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (por_n_i),
    .arm_i   (captured),
    .pin_ok_i(pin_sync),
    .done_o  (stab_done)
  );

  // Pads turn around one clock after the latch closes.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) oe_q <= 1'b0;
    else          oe_q <= captured;
  end

  assign pad_oe_o    = {NUM_STRAPS{oe_q}};
  assign pwr_down_o  = captured & ~pgood_pd_i;
  assign clk_valid_o = captured & stab_done & pgood_pd_i;

  // R4: no pad is driven before the straps are latched
  assert_no_drive_before_capture_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !captured |-> (pad_oe_o == '0));

  // R4: once driven, pads stay outputs
  assert_oe_sticky_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $past(oe_q) |-> (pad_oe_o == '1));

  // R6: power-down and clocks-valid are never both high
  assert_pd_blocks_valid_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    pwr_down_o |-> !clk_valid_o);

  // R5: no power-down request before capture
  assert_no_pd_before_capture_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !captured |-> !pwr_down_o);

endmodule

// File: tb/sim_strap_capture_ctrl.sv
module sim_strap_capture_ctrl;

  localparam int N    = 3;
  localparam int STAB = 32;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic [N-1:0] straps = '0;
  logic         pin = 1'b0;
  logic [N-1:0] word, oe;
  logic         pd, valid;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  strap_capture_ctrl #(.NUM_STRAPS(N), .SYNC_STAGES(2), .STAB_CYCLES(STAB)) u0 (
    .clk_i       (clk),
    .por_n_i     (por_n),
    .strap_pins_i(straps),
    .pgood_pd_i  (pin),
    .strap_word_o(word),
    .pad_oe_o    (oe),
    .pwr_down_o  (pd),
    .clk_valid_o (valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 word in reset", word, 0);
    chk("R1 oe in reset", oe, 0);
    chk("R1 pd in reset", pd, 0);
    chk("R1 valid in reset", valid, 0);
  endtask

  task automatic t_low_before_capture();
    @(negedge clk); por_n = 1'b1; pin = 1'b0; straps = 3'b111;
    repeat (5) @(negedge clk);
    chk("R5 pd low before capture", pd, 0);
    chk("R5 word untouched before capture", word, 0);
    chk("R4 oe low before capture", oe, 0);
  endtask

  task automatic t_capture(input logic [N-1:0] s);
    @(negedge clk); straps = s; pin = 1'b1;
    for (int k = 1; k <= STAB + 3; k++) begin
      @(negedge clk);
      if (k == 2) begin
        chk("R2 word before third edge", word, 0);
        chk("R4 oe before capture", oe, 0);
      end
      if (k == 3) begin
        chk("R2 word at third edge", word, s);
        chk("R4 oe at capture edge", oe, 0);
      end
      if (k == 4) chk("R4 oe one clock after capture", oe, 3'b111);
      if (k == STAB + 2) chk("R7 valid one edge early", valid, 0);
      if (k == STAB + 3) chk("R7 valid after stabilization", valid, 1);
    end
  endtask

  task automatic t_power_down(input logic [N-1:0] s);
    @(negedge clk); pin = 1'b0; straps = ~s;
    #1;
    chk("R6 pd immediate", pd, 1);
    chk("R6 valid drops immediate", valid, 0);
    chk("R4 oe held in power-down", oe, 3'b111);
    repeat (6) @(negedge clk);
    chk("R3 no resample on pd", word, s);
    chk("R6 valid stays low", valid, 0);
    pin = 1'b1;
    #1;
    chk("R8 pd released at once", pd, 0);
    for (int k = 1; k <= STAB + 2; k++) begin
      @(negedge clk);
      if (k == STAB + 1) chk("R8 valid one edge early", valid, 0);
      if (k == STAB + 2) chk("R8 valid after release", valid, 1);
    end
    chk("R3 no resample after release", word, s);
  endtask

  task automatic t_repower(input logic [N-1:0] s);
    @(negedge clk); por_n = 1'b0; pin = 1'b0;
    t_reset();
    @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
    t_capture(s);
    chk("R9 recapture after new reset", word, s);
  endtask

  initial begin
    t_reset();
    t_low_before_capture();
    t_capture(3'b101);
    t_power_down(3'b101);
    t_repower(3'b010);
    t_power_down(3'b010);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule